// File: doc/BRIEF.md
# Receive Word Store for a Serial Avionics Channel

This block files the words that a receive decoder has already assembled for one channel of a serial avionics data bus. Each incoming word arrives with a 32-bit capture time. The pair is written into two memories of equal depth that sit side by side: one holds the data word and the other holds its time. Both memories are always written at the same index. A single control bit sets how the channel is organised. As a ring log, words fill consecutive slots and the host drains them by moving a read pointer. As a latest-value table, each word lands at a slot picked by its 2-bit source/destination field and its 8-bit label, so a slot only ever holds the most recent word with that key.

The host sees both pointers directly and has a one-cycle strobe that moves the read pointer forward. A read port with one cycle of latency returns the data and the time stored at any slot. A channel that has to keep the newest words never stalls: when the ring is full, the oldest entry is dropped and a sticky overflow flag records the loss. Changing the organisation bit starts the channel again from a clean pointer state.

Top module: `rx_store_mgr`

## Requirements
- R1: After reset, rd_ptr and wr_ptr are both 0 and overflow is 0.
- R2: In ring mode (table_mode = 0), each word_vld cycle stores word_data at slot wr_ptr, and wr_ptr then moves up by one, wrapping from 1023 to 0.
- R3: The capture time word_ts is always stored at the same slot as its data word. host_rdata and host_rts show the slot named by host_raddr one clock after that address is applied.
- R4: In table mode (table_mode = 1), the slot is {word_data[9:8], word_data[7:0]} (source/destination field above label). A later word with the same key replaces both the data and the time at that slot, and neither pointer changes.
- R5: A host_adv pulse moves rd_ptr up by one, modulo 1024, when rd_ptr differs from wr_ptr. The pulse has no effect when the ring is empty (rd_ptr equals wr_ptr) or when table mode is in force.
- R6: In ring mode, a write arriving when wr_ptr + 1 equals rd_ptr, with no host_adv in the same cycle, still stores the word. It then moves both pointers up by one, dropping the oldest entry, and sets overflow. overflow stays set until the next mode change or reset.
- R7: When table_mode differs from the mode in force, both pointers return to 0 and overflow clears. A word in that same cycle is filed under the new mode: in ring mode it goes to slot 0 and wr_ptr becomes 1.
- R8: When a read and a write address the same slot in the same cycle, the read returns the contents held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| table_mode | input | 1 | 0 = ring log, 1 = latest-value table |
| word_vld | input | 1 | One-cycle strobe: a decoded word is present |
| word_data | input | 32 | Decoded word |
| word_ts | input | 32 | Capture time of the word |
| host_adv | input | 1 | Host strobe: advance the read pointer |
| host_raddr | input | 10 | Host read slot |
| host_rdata | output | 32 | Data word at host_raddr, one clock later |
| host_rts | output | 32 | Capture time at host_raddr, one clock later |
| rd_ptr | output | 10 | Ring read pointer |
| wr_ptr | output | 10 | Ring write pointer |
| overflow | output | 1 | Sticky flag: an unread entry was overwritten |

## Verification
The hardest state to reach from the ports is a full ring with its write pointer already wrapped past slot 1023. The read pointer is first moved off zero with host_adv pulses until the ring is empty, and 1023 back-to-back words then fill every usable slot. After that, one more word forces the overwrite and drop, a further word arrives together with host_adv to show that the simultaneous advance prevents a second drop, and a read of the same slot in the same cycle as a write checks that the read returns the older contents.

// File: rtl/rx_store_pkg.sv
package rx_store_pkg;

   // word format fields decoded by table mode
   localparam int LABEL_W = 8;
   localparam int SDI_W   = 2;
   localparam int KEY_W   = LABEL_W + SDI_W;

   typedef enum logic {
      ORG_RING  = 1'b0,
      ORG_TABLE = 1'b1
   } org_e;

   // key is source/destination field above label
   function automatic logic [KEY_W-1:0] table_key(input logic [KEY_W-1:0] low_bits);
      return {low_bits[LABEL_W+SDI_W-1:LABEL_W], low_bits[LABEL_W-1:0]};
   endfunction

endpackage

// File: rtl/rx_ptr_ctrl.sv
module rx_ptr_ctrl #(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          table_mode,
   input  logic          word_vld,
   input  logic          host_adv,
   output logic [AW-1:0] rd_ptr,
   output logic [AW-1:0] wr_ptr,
   output logic          overflow,
   output logic [AW-1:0] ring_slot,
   output logic          mode_switch
);
   import rx_store_pkg::*;

   org_e    mode_q;
   logic    ring_wr;
   logic    empty;
   logic    full;
   logic    adv_ok;
   logic    drop;

   assign mode_switch = (org_e'(table_mode) != mode_q);
   assign ring_wr     = word_vld && (org_e'(table_mode) == ORG_RING);
   assign empty       = (rd_ptr == wr_ptr);
   assign full        = ((wr_ptr + AW'(1)) == rd_ptr);
   assign adv_ok      = host_adv && !table_mode && !empty && !mode_switch;
   assign drop        = ring_wr && full && !adv_ok && !mode_switch;
   assign ring_slot   = mode_switch ? '0 : wr_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= ORG_RING;
         rd_ptr   <= '0;
         wr_ptr   <= '0;
         overflow <= 1'b0;
      end else begin
         mode_q <= org_e'(table_mode);
         if (mode_switch) begin
            rd_ptr   <= '0;
            wr_ptr   <= ring_wr ? AW'(1) : '0;
            overflow <= 1'b0;
         end else begin
            if (ring_wr)
               wr_ptr <= wr_ptr + AW'(1);
            if (adv_ok || drop)
               rd_ptr <= rd_ptr + AW'(1);
            if (drop)
               overflow <= 1'b1;
         end
      end
   end

   // R2: a ring write outside a switch steps the write pointer by one
   assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && !table_mode && !mode_switch) |=> (wr_ptr == $past(wr_ptr) + AW'(1)));

   // R4: table mode leaves both pointers alone
   assert_table_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (table_mode && !mode_switch) |=> ($stable(wr_ptr) && $stable(rd_ptr)));

   // R5: an advance on an empty ring with no write is ignored
   assert_empty_adv_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_adv && !word_vld && (rd_ptr == wr_ptr) && !mode_switch) |=> $stable(rd_ptr));

   // R6: after any ring write the ring is never seen empty
   assert_no_collide_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && !table_mode) |=> (wr_ptr != rd_ptr));

   // R6: the overflow flag holds until a mode change
   assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !mode_switch) |=> overflow);

   // R7: a mode change clears the read pointer and the flag
   assert_switch_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_switch |=> (rd_ptr == '0 && !overflow));

endmodule

// File: rtl/rx_slot_sel.sv
module rx_slot_sel #(
   parameter int AW = 10
) (
   input  logic                          table_mode,
   input  logic [rx_store_pkg::KEY_W-1:0] key_bits,
   input  logic [AW-1:0]                 ring_slot,
   output logic [AW-1:0]                 waddr
);
   import rx_store_pkg::*;

   generate
      if (AW == KEY_W) begin : g_full_key
         assign waddr = table_mode ? table_key(key_bits) : ring_slot;
      end else begin : g_bad_width
         $error("rx_slot_sel: slot width must equal key width");
         assign waddr = ring_slot;
      end
   endgenerate

endmodule

// File: rtl/rx_buf_ram.sv
module rx_buf_ram #(
   parameter int W      = 32,
   parameter int DEPTH  = 1024,
   parameter bit RD_REG = 1'b1,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk) rdata <= mem[raddr];
      end else begin : g_rd_comb
         assign rdata = mem[raddr];
      end
   endgenerate

endmodule

// File: rtl/rx_store_mgr.sv
module rx_store_mgr #(
   parameter int DATA_W = 32,
   parameter int TS_W   = 32,
   parameter int DEPTH  = 1024,
   parameter bit RD_REG = 1'b1,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              table_mode,
   input  logic              word_vld,
   input  logic [DATA_W-1:0] word_data,
   input  logic [TS_W-1:0]   word_ts,
   input  logic              host_adv,
   input  logic [AW-1:0]     host_raddr,
   output logic [DATA_W-1:0] host_rdata,
   output logic [TS_W-1:0]   host_rts,
   output logic [AW-1:0]     rd_ptr,
   output logic [AW-1:0]     wr_ptr,
   output logic              overflow
);
   import rx_store_pkg::*;

   generate
      if (DEPTH != (1 << KEY_W)) begin : g_bad_depth
         $error("rx_store_mgr: DEPTH must cover every key");
      end
      if (DATA_W < KEY_W) begin : g_bad_data
         $error("rx_store_mgr: DATA_W too narrow for the key");
      end
   endgenerate

   logic [AW-1:0] ring_slot;
   logic [AW-1:0] waddr;
   logic          mode_switch;

   rx_ptr_ctrl #(.AW(AW)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .table_mode (table_mode),
      .word_vld   (word_vld),
      .host_adv   (host_adv),
      .rd_ptr     (rd_ptr),
      .wr_ptr     (wr_ptr),
      .overflow   (overflow),
      .ring_slot  (ring_slot),
      .mode_switch(mode_switch)
   );

   rx_slot_sel #(.AW(AW)) u_sel (
      .table_mode(table_mode),
      .key_bits  (word_data[KEY_W-1:0]),
      .ring_slot (ring_slot),
      .waddr     (waddr)
   );

   rx_buf_ram #(.W(DATA_W), .DEPTH(DEPTH), .RD_REG(RD_REG)) u_data_ram (
      .clk  (clk),
      .we   (word_vld),
      .waddr(waddr),
      .wdata(word_data),
      .raddr(host_raddr),
      .rdata(host_rdata)
   );

   rx_buf_ram #(.W(TS_W), .DEPTH(DEPTH), .RD_REG(RD_REG)) u_ts_ram (
      .clk  (clk),
      .we   (word_vld),
      .waddr(waddr),
      .wdata(word_ts),
      .raddr(host_raddr),
      .rdata(host_rts)
   );

   // R1: pointers and flag come out of reset cleared
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (rd_ptr == '0 && wr_ptr == '0 && !overflow));

   // R7: a ring word on a switch cycle leaves wr_ptr at one
   assert_switch_ring_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_switch && !table_mode && word_vld) |=> (wr_ptr == AW'(1)));

endmodule

// File: tb/tb_rx_store_mgr.sv
module tb_rx_store_mgr;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        table_mode;
   logic        word_vld;
   logic [31:0] word_data;
   logic [31:0] word_ts;
   logic        host_adv;
   logic [9:0]  host_raddr;
   logic [31:0] host_rdata;
   logic [31:0] host_rts;
   logic [9:0]  rd_ptr;
   logic [9:0]  wr_ptr;
   logic        overflow;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   rx_store_mgr dut (
      .clk(clk), .rst_n(rst_n), .table_mode(table_mode), .word_vld(word_vld),
      .word_data(word_data), .word_ts(word_ts), .host_adv(host_adv),
      .host_raddr(host_raddr), .host_rdata(host_rdata), .host_rts(host_rts),
      .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .overflow(overflow)
   );

   // {data, time} pairs written in ring mode to slots 0..7
   localparam logic [63:0] VEC [8] = '{
      64'h0000_0001_0000_1000, 64'hFFFF_FFFF_0000_1001,
      64'h1234_5678_0000_1002, 64'h8000_0000_0000_1003,
      64'h0000_03FF_DEAD_BEEF, 64'hA5A5_5A5A_0000_1005,
      64'h7FFF_0000_0000_1006, 64'h0F0F_F0F0_FFFF_FFFF
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(input logic [31:0] d, input logic [31:0] t, input logic adv);
      word_vld  = 1'b1;
      word_data = d;
      word_ts   = t;
      host_adv  = adv;
      @(negedge clk);
      word_vld  = 1'b0;
      host_adv  = 1'b0;
   endtask

   task automatic adv_once();
      host_adv = 1'b1;
      @(negedge clk);
      host_adv = 1'b0;
   endtask

   task automatic peek(input logic [9:0] a, output logic [31:0] d, output logic [31:0] t);
      host_raddr = a;
      @(negedge clk);
      d = host_rdata;
      t = host_rts;
   endtask

   task automatic ptrs(input string req, input int rd_e, input int wr_e, input logic ov_e);
      chk({req, " rd_ptr"}, 32'(rd_ptr), 32'(rd_e));
      chk({req, " wr_ptr"}, 32'(wr_ptr), 32'(wr_e));
      chk({req, " overflow"}, 32'(overflow), 32'(ov_e));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d, t;
      rst_n = 1'b0; table_mode = 1'b0; word_vld = 1'b0; word_data = '0;
      word_ts = '0; host_adv = 1'b0; host_raddr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      ptrs("R1 reset", 0, 0, 1'b0);

      // vector table: ring writes, then read back data and time
      for (int i = 0; i < 8; i++) begin
         put(VEC[i][63:32], VEC[i][31:0], 1'b0);
         chk("R2 wr_ptr step", 32'(wr_ptr), 32'(i + 1));
      end
      for (int i = 0; i < 8; i++) begin
         peek(10'(i), d, t);
         chk("R2 ring data", d, VEC[i][63:32]);
         chk("R3 ring time", t, VEC[i][31:0]);
      end

      // R5: advance, then advance on empty is ignored
      for (int i = 0; i < 8; i++) adv_once();
      ptrs("R5 drained", 8, 8, 1'b0);
      adv_once();
      ptrs("R5 empty adv ignored", 8, 8, 1'b0);

      // R2 wrap: fill 1023 slots from slot 8
      for (int k = 1; k <= 1023; k++) put(32'hA000_0000 + 32'(k), 32'(k), 1'b0);
      ptrs("R2 wrapped full", 8, 7, 1'b0);
      peek(10'd1023, d, t);
      chk("R2 slot 1023 data", d, 32'hA000_03F8);
      chk("R3 slot 1023 time", t, 32'd1016);

      // R6: overflow write drops oldest
      put(32'hB000_0001, 32'h5000_0001, 1'b0);
      ptrs("R6 overflow", 9, 8, 1'b1);
      peek(10'd7, d, t);
      chk("R6 overwrite data", d, 32'hB000_0001);
      chk("R3 overwrite time", t, 32'h5000_0001);

      // R6: full with simultaneous advance: no drop, flag stays set
      put(32'hB000_0002, 32'h5000_0002, 1'b1);
      ptrs("R6 adv with full write", 10, 9, 1'b1);

      // R8: read and write same slot in one cycle
      host_raddr = 10'd9;
      put(32'hB000_0003, 32'h5000_0003, 1'b0);
      chk("R8 old data on collision", host_rdata, 32'hA000_0002);
      chk("R8 old time on collision", host_rts, 32'd2);
      peek(10'd9, d, t);
      chk("R8 new data after", d, 32'hB000_0003);
      ptrs("R6 second drop", 11, 10, 1'b1);

      // R7: switch to table with a word; R4 key addressing
      table_mode = 1'b1;
      put(32'h0001_0235, 32'h7000_0001, 1'b0);
      ptrs("R7 switch to table", 0, 0, 1'b0);
      peek(10'h235, d, t);
      chk("R4 table data", d, 32'h0001_0235);
      chk("R4 table time", t, 32'h7000_0001);
      put(32'hFFF0_0235, 32'h7000_0002, 1'b0);
      put(32'h0002_0135, 32'h7000_0003, 1'b0);
      ptrs("R4 pointers held", 0, 0, 1'b0);
      peek(10'h235, d, t);
      chk("R4 replaced data", d, 32'hFFF0_0235);
      chk("R4 replaced time", t, 32'h7000_0002);
      peek(10'h135, d, t);
      chk("R4 other sdi data", d, 32'h0002_0135);
      adv_once();
      ptrs("R5 adv ignored in table", 0, 0, 1'b0);

      // R7: back to ring with a word on the switch cycle
      table_mode = 1'b0;
      put(32'hC000_0001, 32'h9000_0001, 1'b0);
      ptrs("R7 switch to ring", 0, 1, 1'b0);
      peek(10'd0, d, t);
      chk("R7 ring slot 0 data", d, 32'hC000_0001);
      chk("R7 ring slot 0 time", t, 32'h9000_0001);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule